// File: doc/BRIEF.md
# Three-Wire Pulse Serializer

This block accepts an 8-bit word through a valid/ready handshake and sends it over three output wires, one bit at a time. No clock is sent with the data. Each bit becomes one pulse on exactly one of the three wires. A three-state protocol register picks the wire, based on the current state and the bit value, so a receiver can find bit boundaries from which wire pulsed and recover each bit from the pair of old and new state.

Eight bit slots send bits 0 to 7 in that order. Each slot hands its new protocol state to the next slot, and the final slot hands it on to the first slot of the following word, as a token would move around a ring. Two runtime settings, both counted in clock cycles, control the pulse width and the spacing between the leading edges of pulses. Both settings are captured when a word is accepted. When no word is offered, all three wires stay low for as long as the link is idle.

Top module: `tw_pulse_ser`

## Requirements
- R1: After reset all three wires are low, in_ready is high, and the protocol state is 0 (state n is wire n, one-hot).
- R2: The next state is taken from the current state and the bit: from state 0, bit 1 goes to 1 and bit 0 goes to 2; from state 1, bit 1 goes to 0 and bit 0 goes to 2; from state 2, bit 1 goes to 1 and bit 0 goes to 0.
- R3: Each bit produces exactly one pulse, on tw_wire[n] where n is the new state. The first pulse of a word starts on the cycle after the accepting edge.
- R4: Two successive pulses are never on the same wire.
- R5: Bits go out in the order in_data[0] first to in_data[7] last. The protocol state carries over from each bit to the next and from one word to the next.
- R6: Each pulse stays high for cfg_width cycles. A value of 0 is treated as 1.
- R7: Leading edges of pulses are cfg_period cycles apart. If cfg_period is less than the effective width plus one, the spacing is the effective width plus one.
- R8: While no word is in flight, all wires are low.
- R9: in_ready is high when the block is idle, and also on the last cycle of the final slot of a word. A word offered on that last cycle is accepted at once, so back-to-back words keep the same leading-edge spacing. in_ready is low at all other times.
- R10: At most one wire is high in any cycle.
- R11: The width and period settings are captured when a word is accepted. Changing them while that word is in flight has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block accepts the offered word on this edge |
| in_data | input | 8 | Word to send, bit 0 first |
| cfg_width | input | 8 | Pulse width in cycles |
| cfg_period | input | 8 | Leading-edge spacing in cycles |
| tw_wire | output | 3 | The three serial wires, active high |

## Verification
The assertions check four properties on every cycle: at most one wire is high, no new pulse repeats the wire of the one before, the wires are low whenever in_ready is high, and each accepted word drops in_ready and raises exactly one wire on the next cycle. The state transition table, the bit order, the carry of state from word to word, the exact width and spacing of pulses (including the clamp), and the rule that setting changes are ignored during a word can only be shown by the bench scenarios. The bench checks them against a reference model of the protocol state, sampled on every cycle of each word.

// File: rtl/tw_pulse_ser.sv
module tw_pulse_ser #(
  parameter int SLOTS = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SLOTS-1:0] in_data,
  input  logic [CNT_W-1:0] cfg_width,
  input  logic [CNT_W-1:0] cfg_period,
  output logic [2:0]       tw_wire
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int TW     = CNT_W + 1;
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic              busy;
  logic [SLOT_W-1:0] slot;
  logic [TW-1:0]     cnt;
  logic [TW-1:0]     width_q;
  logic [TW-1:0]     period_q;
  logic [SLOTS-1:0]  word;
  logic [2:0]        state;
  logic [2:0]        wire_q;

  function automatic logic [2:0] step(input logic [2:0] s, input logic b);
    case (s)
      3'b001:  step = b ? 3'b010 : 3'b100;
      3'b010:  step = b ? 3'b001 : 3'b100;
      default: step = b ? 3'b010 : 3'b001;
    endcase
  endfunction

  logic [TW-1:0] w_eff, p_eff;
  assign w_eff = (cfg_width == '0) ? TW'(1) : {1'b0, cfg_width};
  assign p_eff = ({1'b0, cfg_period} > w_eff) ? {1'b0, cfg_period} : w_eff + TW'(1);

  logic slot_end, last_slot, accept;
  logic [SLOT_W-1:0] nxt_slot;
  logic [2:0] first_ns, slot_ns;

  assign slot_end  = busy && (cnt == period_q - TW'(1));
  assign last_slot = (slot == LAST);
  assign in_ready  = !busy || (slot_end && last_slot);
  assign accept    = in_valid && in_ready;
  assign nxt_slot  = last_slot ? '0 : slot + SLOT_W'(1);
  assign first_ns  = step(state, in_data[0]);
  assign slot_ns   = step(state, word[nxt_slot]);
  assign tw_wire   = wire_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      slot     <= '0;
      cnt      <= '0;
      width_q  <= TW'(1);
      period_q <= TW'(2);
      word     <= '0;
      state    <= 3'b001;
      wire_q   <= 3'b000;
    end else if (accept) begin
      busy     <= 1'b1;
      slot     <= '0;
      cnt      <= '0;
      word     <= in_data;
      width_q  <= w_eff;
      period_q <= p_eff;
      state    <= first_ns;
      wire_q   <= first_ns;
    end else if (slot_end) begin
      cnt <= '0;
      if (last_slot) begin
        busy   <= 1'b0;
        wire_q <= 3'b000;
      end else begin
        slot   <= nxt_slot;
        state  <= slot_ns;
        wire_q <= slot_ns;
      end
    end else if (busy) begin
      cnt <= cnt + TW'(1);
      if (cnt == width_q - TW'(1))
        wire_q <= 3'b000;
    end
  end
endmodule

module tw_pulse_ser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [2:0] tw_wire
);
  logic [2:0] prev_q, last_q;
  logic       seen_q;
  logic       rise;
  assign rise = (|tw_wire) && !(|prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 3'b000;
      last_q <= 3'b000;
      seen_q <= 1'b0;
    end else begin
      prev_q <= tw_wire;
      if (rise) begin
        last_q <= tw_wire;
        seen_q <= 1'b1;
      end
    end
  end

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tw_wire));
  p_no_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && rise) |-> (tw_wire != last_q));
  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (tw_wire == 3'b000));
  p_accept_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ($countones(tw_wire) == 1));
  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
endmodule

bind tw_pulse_ser tw_pulse_ser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .in_ready(in_ready), .tw_wire(tw_wire)
);

// File: tb/tb_tw_pulse_ser.sv
module tb_tw_pulse_ser;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic [7:0] cfg_width = 8'd1;
  logic [7:0] cfg_period = 8'd2;
  logic [2:0] tw_wire;

  int total = 0;
  int fails = 0;
  int mstate = 0;
  int last_wire = -1;

  always #2 clk = ~clk;

  tw_pulse_ser dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_width(cfg_width), .cfg_period(cfg_period),
    .tw_wire(tw_wire)
  );

  function automatic int nxt(input int s, input logic b);
    case (s)
      0:       return b ? 1 : 2;
      1:       return b ? 0 : 2;
      default: return b ? 1 : 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sends one word starting at a negedge with in_ready expected high; ends on
  // the negedge of the word's last cycle, so a following call is back to back.
  task automatic send(input logic [7:0] d, input int w, input int p, input bit disturb);
    int we, pe, rbad, ohbad, repbad;
    we = (w == 0) ? 1 : w;
    pe = (p > we) ? p : we + 1;
    rbad = 0; ohbad = 0; repbad = 0;
    chk(in_ready === 1'b1, "R9 ready before offer", int'(in_ready), 1);
    in_data = d; cfg_width = 8'(w); cfg_period = 8'(p); in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (disturb) begin
      cfg_width = 8'd1; cfg_period = 8'd9;
    end
    for (int s = 0; s < 8; s++) begin
      int ns, bad_act, bad_exp;
      bit bad;
      ns = nxt(mstate, d[s]);
      mstate = ns;
      bad = 0; bad_act = 0; bad_exp = 0;
      if (ns == last_wire) repbad++;
      last_wire = ns;
      for (int o = 0; o < pe; o++) begin
        logic [2:0] exp;
        bit lastc;
        exp = (o < we) ? 3'(1 << ns) : 3'b000;
        lastc = (s == 7) && (o == pe - 1);
        if (tw_wire !== exp && !bad) begin
          bad = 1; bad_act = int'(tw_wire); bad_exp = int'(exp);
        end
        if (!$onehot0(tw_wire)) ohbad++;
        if (in_ready !== lastc) rbad++;
        if (!lastc) @(negedge clk);
      end
      chk(!bad, $sformatf("R2 R3 R5 R6 R7 R11 slot %0d", s), bad_act, bad_exp);
    end
    chk(rbad == 0, "R9 ready timing", rbad, 0);
    chk(ohbad == 0, "R10 one wire", ohbad, 0);
    chk(repbad == 0, "R4 wire repeat", repbad, 0);
  endtask

  task automatic t_reset();
    chk(tw_wire === 3'b000, "R1 wires at reset", int'(tw_wire), 0);
    chk(in_ready === 1'b1, "R1 ready at reset", int'(in_ready), 1);
  endtask

  task automatic t_idle(input int n);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tw_wire !== 3'b000 || in_ready !== 1'b1) bad++;
    end
    chk(bad == 0, "R8 idle link", bad, 0);
  endtask

  initial begin
    #(4 * 150000);
    fails++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();                        // R1
    t_idle(5);                        // R8
    send(8'hA5, 2, 4, 0);             // R2 R3 R5 from state 0
    t_idle(7);                        // R8 between words
    send(8'h00, 3, 5, 0);             // R2 zeros
    send(8'hFF, 1, 3, 0);             // R5 R9 back to back, ones
    send(8'h3C, 0, 0, 0);             // R6 R7 zero settings clamp
    t_idle(3);
    send(8'h96, 5, 3, 0);             // R7 clamp to width+1
    send(8'h5A, 3, 6, 1);             // R11 settings changed mid word
    t_idle(4);
    send(8'h81, 4, 12, 0);            // R7 long spacing
    t_idle(2);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule